// File: doc/BRIEF.md
# IRQ Wake and SMI Gate Monitor

This block sits beside an interrupt controller and turns interrupt activity into power-management events. It watches a fixed subset of sixteen interrupt request lines, resynchronises them to the local clock, and runs an idle countdown. While the countdown runs, the stop-clock output stays released. When the countdown expires, stop-clock is asserted and stays asserted until an enabled interrupt line is seen high or software programs a new initial count.

The same synchronised lines can also raise a system-management interrupt. After one SMI pulse has been issued, an internal gate closes. Any further interrupt-caused SMI is held back until software opens the gate again. A request that arrives while the gate is closed is remembered and issued once the gate opens. Software programs the block through a simple write-only port with four word addresses.

Timer states: RUN (counting, stop-clock released) and STOP (expired, stop-clock asserted). Transitions: RUN to STOP on the tick that empties the count. STOP or RUN to RUN with a reload on a wake event or on an initial-count write. Gate states: OPEN, FIRE and HELD. Transitions: OPEN to FIRE on a request or a pending flag. FIRE to HELD always. HELD to OPEN on a gate-clear write.

Top module: `irq_wake_monitor`

## Requirements
- R1: Only IRQ numbers 15, 9, 8, 7, 6, 5, 4, 3 and 1 are monitored (monitor mask 0x83FA, bit n = IRQ n). Lines 0, 2 and 10 to 14 never wake the timer or raise SMI, even when their enable bits are set.
- R2: Register writes use wr_addr: 0 = wake enable mask (bit n = IRQ n), 1 = initial count, 2 = SMI enable mask (bit n = IRQ n), 3 = gate control (bit 0). A write to address 1 reloads the timer with the written value and releases stop-clock after the write edge.
- R3: In RUN, each clock with tick_en high decrements the count. With initial count N ≥ 1, stpclk_n goes low after the edge that samples the N-th tick. With N = 0, it goes low after the first tick.
- R4: An interrupt-caused SMI drives smi_n low for exactly one cycle. smi_n goes low after the third rising edge that samples an enabled, monitored line high.
- R5: An enabled, monitored line held high reloads the count to the initial value and drives stpclk_n high after the third rising edge that samples it, including from STOP.
- R6: After an SMI pulse, smi_n stays high until a write to address 3 with bit 0 = 0. A write with bit 0 = 1 has no effect.
- R7: If an SMI request is seen while the gate is held, one SMI pulse is issued after the gate is cleared, even if the line has since gone low. The pending request is consumed by that pulse.
- R8: Interrupts are level sampled. An enabled line that stays high keeps the timer reloaded, so stpclk_n never falls while it stays high.
- R9: While rst_n is low at a rising edge, the block clears both enable masks, loads the count with the reset initial value, opens the gate and drives stpclk_n and smi_n high.
- R10: Once in STOP, stpclk_n stays low through further ticks until a wake event or an initial-count write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer decrement strobe |
| irq_in | input | 16 | Asynchronous interrupt request lines, bit n = IRQ n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| stpclk_n | output | 1 | Stop-clock request, active low |
| smi_n | output | 1 | System-management interrupt, active low |

## Verification
A count register that is stuck or off by one shows up at stpclk_n one tick early or late, so it can be found within the tick count of one vector. A gate FSM left in the wrong state either drops an SMI pulse or adds one. This shows on smi_n within a few cycles of the gate-clear write or of the request. A broken pending flag shows as a missing pulse after the clear. A wrong monitor mask shows as wake or SMI activity on an unmonitored line within three cycles.

// File: rtl/pwrmon_pkg.sv
package pwrmon_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_WAKE_EN = 2'd0,
        REG_INIT    = 2'd1,
        REG_SMI_EN  = 2'd2,
        REG_GATE    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        TMR_RUN  = 1'b0,
        TMR_STOP = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        GATE_OPEN = 2'd0,
        GATE_FIRE = 2'd1,
        GATE_HELD = 2'd2
    } gate_state_e;

endpackage

// File: rtl/pwrmon_sync.sv
module pwrmon_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pwrmon_regs.sv
module pwrmon_regs
    import pwrmon_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter logic [CNT_W-1:0] RESET_COUNT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  wake_en,
    output logic [REG_W-1:0]  smi_en,
    output logic              init_load,
    output logic [CNT_W-1:0]  load_val,
    output logic              gate_clr
);

    logic [CNT_W-1:0] init_q;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en <= '0;
            smi_en  <= '0;
            init_q  <= RESET_COUNT;
        end else if (wr_en) begin
            unique case (sel)
                REG_WAKE_EN: wake_en <= wr_data;
                REG_INIT:    init_q  <= wr_data[CNT_W-1:0];
                REG_SMI_EN:  smi_en  <= wr_data;
                REG_GATE:    ;
            endcase
        end
    end

    assign init_load = wr_en && (sel == REG_INIT);
    assign load_val  = init_load ? wr_data[CNT_W-1:0] : init_q;
    assign gate_clr  = wr_en && (sel == REG_GATE) && !wr_data[0];

endmodule

// File: rtl/pwrmon_fastoff.sv
module pwrmon_fastoff
    import pwrmon_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter logic [CNT_W-1:0] RESET_COUNT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wake,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             stop_n
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (wake || load) begin
            st_d  = TMR_RUN;
            cnt_d = load_val;
        end else begin
            unique case (st_q)
                TMR_RUN: begin
                    if (tick_en) begin
                        if (cnt_q <= LAST) begin
                            cnt_d = '0;
                            st_d  = TMR_STOP;
                        end else begin
                            cnt_d = cnt_q - LAST;
                        end
                    end
                end
                TMR_STOP: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TMR_RUN;
            cnt_q <= RESET_COUNT;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        stop_n = (st_q != TMR_STOP);
    end

endmodule

// File: rtl/pwrmon_smi_gate.sv
module pwrmon_smi_gate
    import pwrmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic gate_clr,
    output logic smi_n
);

    gate_state_e st_q, st_d;
    logic        pend_q, pend_d;

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        unique case (st_q)
            GATE_OPEN: begin
                if (trig || pend_q) begin
                    st_d   = GATE_FIRE;
                    pend_d = 1'b0;
                end
            end
            GATE_FIRE: begin
                st_d = GATE_HELD;
            end
            GATE_HELD: begin
                if (trig) pend_d = 1'b1;
                if (gate_clr) st_d = GATE_OPEN;
            end
            default: begin
                st_d   = GATE_OPEN;
                pend_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= GATE_OPEN;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        smi_n = (st_q != GATE_FIRE);
    end

endmodule

// File: rtl/irq_wake_monitor.sv
module irq_wake_monitor
    import pwrmon_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] RESET_COUNT = '1,
    parameter logic [REG_W-1:0] MON_MASK    = 16'h83FA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [REG_W-1:0]  irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              stpclk_n,
    output logic              smi_n
);

    logic [REG_W-1:0] irq_s;
    logic [REG_W-1:0] wake_en;
    logic [REG_W-1:0] smi_en;
    logic             init_load;
    logic [CNT_W-1:0] load_val;
    logic             gate_clr;
    logic             wake_hit;
    logic             smi_hit;

    pwrmon_sync #(
        .W      (REG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (irq_s)
    );

    pwrmon_regs #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wake_en   (wake_en),
        .smi_en    (smi_en),
        .init_load (init_load),
        .load_val  (load_val),
        .gate_clr  (gate_clr)
    );

    assign wake_hit = |(irq_s & wake_en & MON_MASK);
    assign smi_hit  = |(irq_s & smi_en & MON_MASK);

    pwrmon_fastoff #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wake     (wake_hit),
        .load     (init_load),
        .load_val (load_val),
        .stop_n   (stpclk_n)
    );

    pwrmon_smi_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (smi_hit),
        .gate_clr (gate_clr),
        .smi_n    (smi_n)
    );

endmodule

// File: rtl/pwrmon_checker.sv
module pwrmon_checker
    import pwrmon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              wake_hit,
    input logic              stpclk_n,
    input logic              smi_n
);

    logic blocked_q;
    logic init_wr;
    logic clr_wr;

    assign init_wr = wr_en && (wr_addr == REG_INIT);
    assign clr_wr  = wr_en && (wr_addr == REG_GATE) && !wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n)      blocked_q <= 1'b0;
        else if (!smi_n) blocked_q <= 1'b1;
        else if (clr_wr) blocked_q <= 1'b0;
    end

    // R4: the SMI pulse lasts one cycle
    a_r4_smi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |=> smi_n);

    // R6: no new SMI before the gate is cleared
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_q |-> smi_n);

    // R5: a wake event releases stop-clock
    a_r5_wake_release: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |=> stpclk_n);

    // R3: stop-clock falls only on a tick with no wake event
    a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stpclk_n) |-> ($past(tick_en) && !$past(wake_hit)));

    // R10: STOP is held without a wake event or a count write
    a_r10_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!stpclk_n && !wake_hit && !init_wr) |=> !stpclk_n);

endmodule

bind irq_wake_monitor pwrmon_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wake_hit (wake_hit),
    .stpclk_n (stpclk_n),
    .smi_n    (smi_n)
);

// File: tb/sim_irq_wake_monitor.sv
`timescale 1ns/1ps
module sim_irq_wake_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        stpclk_n;
    logic        smi_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_wake_monitor u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .irq_in   (irq_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stpclk_n (stpclk_n),
        .smi_n    (smi_n)
    );

    typedef struct packed {
        logic [15:0] init;
        logic [15:0] mask;
        logic [15:0] irq;
        logic [7:0]  ticks;
        logic        exp_stp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'd5, 16'h0000, 16'h0000, 8'd5,  1'b0},  // R3 expires on 5th tick
        '{16'd5, 16'h0000, 16'h0000, 8'd4,  1'b1},  // R3 one tick short
        '{16'd0, 16'h0000, 16'h0000, 8'd1,  1'b0},  // R3 zero count
        '{16'd3, 16'h0008, 16'h0008, 8'd10, 1'b1},  // R8 held line
        '{16'd3, 16'h0004, 16'h0004, 8'd3,  1'b0},  // R1 IRQ2 ignored
        '{16'd3, 16'h7C01, 16'h7C01, 8'd3,  1'b0},  // R1 IRQ0,10-14 ignored
        '{16'd3, 16'h0002, 16'h8000, 8'd3,  1'b0},  // R5 disabled line
        '{16'd3, 16'h8000, 16'h8000, 8'd3,  1'b1},  // R5 IRQ15 wakes
        '{16'd2, 16'h0200, 16'h0200, 8'd2,  1'b1}   // R8 IRQ9 held
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic count_smi(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin
            @(negedge clk);
            if (!smi_n) pulses++;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p;
        @(negedge clk);
        cyc(3);
        check(stpclk_n == 1'b1, "R9 reset stpclk_n", stpclk_n, 1);
        check(smi_n == 1'b1, "R9 reset smi_n", smi_n, 1);
        rst_n = 1'b1;
        cyc(2);

        // R3 / R10: expiry and hold
        wr(2'd0, 16'h000C);
        wr(2'd1, 16'd2);
        tick(2);
        check(stpclk_n == 1'b0, "R3 expiry after 2 ticks", stpclk_n, 0);
        tick(3);
        check(stpclk_n == 1'b0, "R10 stays stopped", stpclk_n, 0);
        // R1: IRQ2 enabled but unmonitored
        irq_in = 16'h0004;
        cyc(4);
        check(stpclk_n == 1'b0, "R1 unmonitored IRQ2", stpclk_n, 0);
        // R5: wake latency from STOP
        irq_in = 16'h0008;
        cyc(1);
        check(stpclk_n == 1'b0, "R5 latency edge1", stpclk_n, 0);
        cyc(1);
        check(stpclk_n == 1'b0, "R5 latency edge2", stpclk_n, 0);
        cyc(1);
        check(stpclk_n == 1'b1, "R5 wake at edge3", stpclk_n, 1);
        irq_in = '0;
        cyc(3);
        tick(1);
        check(stpclk_n == 1'b1, "R5 reloaded count", stpclk_n, 1);
        tick(1);
        check(stpclk_n == 1'b0, "R5 reloaded to init 2", stpclk_n, 0);
        // R2: count write releases
        wr(2'd1, 16'd5);
        check(stpclk_n == 1'b1, "R2 init write releases", stpclk_n, 1);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            automatic vec_t v = VECS[i];
            irq_in = '0;
            cyc(3);
            wr(2'd0, v.mask);
            wr(2'd1, v.init);
            irq_in = v.irq;
            cyc(3);
            tick(int'(v.ticks));
            check(stpclk_n == v.exp_stp, $sformatf("R3/R1/R5/R8 vector %0d", i),
                  stpclk_n, v.exp_stp);
        end
        irq_in = '0;
        cyc(3);

        // R4: SMI latency and width
        wr(2'd2, 16'h0010);
        irq_in = 16'h0010;
        cyc(1);
        check(smi_n == 1'b1, "R4 no SMI edge1", smi_n, 1);
        cyc(1);
        check(smi_n == 1'b1, "R4 no SMI edge2", smi_n, 1);
        cyc(1);
        check(smi_n == 1'b0, "R4 SMI at edge3", smi_n, 0);
        cyc(1);
        check(smi_n == 1'b1, "R4 one-cycle pulse", smi_n, 1);
        // R6: held gate
        count_smi(10, p);
        check(p == 0, "R6 blocked while held", p, 0);
        wr(2'd3, 16'h0001);
        count_smi(6, p);
        check(p == 0, "R6 write of 1 ignored", p, 0);
        // R7: pending issue after clear
        irq_in = '0;
        cyc(3);
        wr(2'd3, 16'h0000);
        count_smi(5, p);
        check(p == 1, "R7 pending SMI after clear", p, 1);
        wr(2'd3, 16'h0000);
        count_smi(6, p);
        check(p == 0, "R7 pending consumed", p, 0);
        // R1: unmonitored SMI line
        wr(2'd2, 16'h0004);
        irq_in = 16'h0004;
        count_smi(8, p);
        check(p == 0, "R1 IRQ2 raises no SMI", p, 0);
        irq_in = '0;
        cyc(3);

        // R9: reset clears masks
        wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'hFFFF);
        wr(2'd1, 16'd4);
        tick(4);
        rst_n = 1'b0;
        cyc(2);
        check(stpclk_n == 1'b1, "R9 reset releases stop", stpclk_n, 1);
        check(smi_n == 1'b1, "R9 reset smi_n high", smi_n, 1);
        rst_n = 1'b1;
        wr(2'd1, 16'd2);
        irq_in = 16'hFFFF;
        cyc(3);
        tick(2);
        check(stpclk_n == 1'b0, "R9 wake mask cleared", stpclk_n, 0);
        count_smi(6, p);
        check(p == 0, "R9 SMI mask cleared", p, 0);
        irq_in = '0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule